// File: doc/BRIEF.md
# Parallel Mask ROM Read Controller

This block sits between a synchronous host and an asynchronous parallel mask ROM whose organisation is chosen per access. In word mode the ROM delivers 16-bit words from a 22-bit word address. In byte mode it delivers 8-bit bytes from a 23-bit byte address. The lowest address bit then travels on the ROM's top data pin, which becomes an input to the ROM. The controller steers that shared pin for each mode, and it zero-extends byte results because the ROM leaves its upper data lanes floating in byte mode.

All ROM timing is met by counting clock cycles. Each wait time is given in nanoseconds and converted to whole cycles, rounding up, from a clock-period parameter. After reset the chip enable is held inactive for a power-up wait. Each access drives the address and mode, asserts chip enable and output enable, and waits for the longer of the access and output-enable delays. When the mode differs from the previous access, it also waits out the mode recovery time. The controller then samples the data, returns it to the host with a one-cycle acknowledge, releases the ROM and waits for the bus to float before it accepts the next request. The output-enable pin can be active low, active high, or held at a fixed level when the ROM ignores it.

Top module: `mrom_rd_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, `rom_ce_n` is 1 and `ack` is 0. `rom_word` is 1 (word mode), `rom_a1_oe` is 0 (shared pin released), and `rom_oe` is at its inactive level.
- R2: After reset, `rom_ce_n` stays 1 for at least ceil(PWRUP_NS/CLK_NS) cycles, even while `req` is held high.
- R3: A word-mode access (`byte_mode`=0) drives `rom_word`=1, `rom_addr`=`addr[21:0]` and `rom_a1_oe`=0. It returns `rdata` equal to all 16 bits of `rom_dq_i`, with bit 15 taken from the shared pin.
- R4: A byte-mode access (`byte_mode`=1) drives `rom_word`=0, `rom_addr`=`addr[22:1]`, `rom_a1_oe`=1 and `rom_a1_o`=`addr[0]`. It returns `rdata` = {8'h00, `rom_dq_i[7:0]`}.
- R5: Data is sampled only after chip enable and output enable have been active for at least max(ceil(TACC_NS/CLK_NS), ceil(TOE_NS/CLK_NS)) cycles.
- R6: When an access uses a different mode from the previous one (word mode after reset), chip enable stays active for at least ceil(TMODE_NS/CLK_NS) cycles before sampling.
- R7: `ack` is a one-cycle pulse with `rdata` valid in that cycle. A request that is held high yields one access per acknowledge, and no request is accepted while an access or release is in progress.
- R8: Between two accesses, `rom_ce_n` stays 1 for at least ceil(TDF_NS/CLK_NS) cycles.
- R9: While `rom_ce_n` is 0, `rom_addr`, `rom_word` and `rom_a1_o` do not change, whatever happens on `addr` and `byte_mode`.
- R10: `OE_POL` selects the output-enable pin behaviour. With 0 the pin is low exactly while chip enable is active. With 1 it is high exactly while chip enable is active. With 2 it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host read request, held until ack |
| addr | input | 23 | Host address: word address in [21:0], or byte address in [22:0] |
| byte_mode | input | 1 | 1 selects byte organisation for this request |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| rom_addr | output | 22 | ROM address pins |
| rom_word | output | 1 | ROM mode select, 1 = word mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe | output | 1 | ROM output enable, polarity set by OE_POL |
| rom_a1_o | output | 1 | Value driven onto the shared top data pin in byte mode |
| rom_a1_oe | output | 1 | Drive enable for the shared pin |
| rom_dq_i | input | 16 | ROM data pins as seen by the controller; bit 15 is the shared pin |

## Verification
On every cycle the bound checker watches the chip-enable timing. It checks the power-up hold, the minimum active time (the longer one after a mode change), the released gap between accesses, the stability of address and mode while the chip is enabled, the direction of the shared pin in each mode, the output-enable level, the single-cycle acknowledge and the empty upper byte of byte results. Only the bench scenarios can show that the sampled value is correct. To do so they use a ROM model that returns garbage until its own timing and pin-direction conditions are met. The same scenarios show that each byte lane is picked by the low address bit, that a held request produces spaced, separate accesses, and that address changes in the middle of an access are ignored.

// File: rtl/mrom_pkg.sv
package mrom_pkg;

    typedef enum logic [1:0] {
        ST_PWRUP   = 2'd0,
        ST_IDLE    = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_RELEASE = 2'd3
    } rd_state_e;

    localparam int OE_ACT_LOW  = 0;
    localparam int OE_ACT_HIGH = 1;
    localparam int OE_FIXED    = 2;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mrom_wait_timer.sv
module mrom_wait_timer #(
    parameter int W       = 5,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mrom_lane.sv
module mrom_lane #(
    parameter int DATA_W = 16
) (
    input  logic              word,
    input  logic [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] data
);
    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        if (word)
            data = dq;
        else
            data = {{(DATA_W-BYTE_W){1'b0}}, dq[BYTE_W-1:0]};
    end
endmodule

// File: rtl/mrom_oe_pin.sv
module mrom_oe_pin #(
    parameter int OE_POL = 0
) (
    input  logic oe_act,
    output logic pin
);
    generate
        if (OE_POL == mrom_pkg::OE_ACT_LOW) begin : g_low
            assign pin = ~oe_act;
        end else if (OE_POL == mrom_pkg::OE_ACT_HIGH) begin : g_high
            assign pin = oe_act;
        end else begin : g_fixed
            logic unused_act;
            assign unused_act = oe_act;
            assign pin = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mrom_rd_ctrl.sv
module mrom_rd_ctrl #(
    parameter int CLK_NS   = 10,
    parameter int PWRUP_NS = 200,
    parameter int TACC_NS  = 100,
    parameter int TOE_NS   = 25,
    parameter int TDF_NS   = 25,
    parameter int TMODE_NS = 100,
    parameter int OE_POL   = 0,
    parameter int ROW_W    = 22,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ROW_W:0]    addr,
    input  logic              byte_mode,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ROW_W-1:0]  rom_addr,
    output logic              rom_word,
    output logic              rom_ce_n,
    output logic              rom_oe,
    output logic              rom_a1_o,
    output logic              rom_a1_oe,
    input  logic [DATA_W-1:0] rom_dq_i
);
    import mrom_pkg::*;

    localparam int NPW  = ns_to_cyc(PWRUP_NS, CLK_NS);
    localparam int NACC = max2(ns_to_cyc(TACC_NS, CLK_NS), ns_to_cyc(TOE_NS, CLK_NS));
    localparam int NCHG = max2(NACC, ns_to_cyc(TMODE_NS, CLK_NS));
    localparam int NDF  = ns_to_cyc(TDF_NS, CLK_NS);
    localparam int NMAX = max2(max2(NPW, NCHG), NDF);
    localparam int TW   = $clog2(NMAX + 1);

    rd_state_e         state;
    logic              oe_act;
    logic              t_load;
    logic [TW-1:0]     t_val;
    logic              t_done;
    logic              new_word;
    logic [ROW_W-1:0]  new_row;
    logic [DATA_W-1:0] lane_data;

    mrom_wait_timer #(.W(TW), .RST_VAL(NPW - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    mrom_lane #(.DATA_W(DATA_W)) u_lane (
        .word (rom_word),
        .dq   (rom_dq_i),
        .data (lane_data)
    );

    mrom_oe_pin #(.OE_POL(OE_POL)) u_oe (
        .oe_act (oe_act),
        .pin    (rom_oe)
    );

    assign new_word = ~byte_mode;
    assign new_row  = byte_mode ? addr[ROW_W:1] : addr[ROW_W-1:0];

    // Timer reload: access window on request, float window on sample.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (state == ST_IDLE && req) begin
            t_load = 1'b1;
            t_val  = (new_word != rom_word) ? TW'(NCHG - 1) : TW'(NACC - 1);
        end else if (state == ST_ACCESS && t_done) begin
            t_load = 1'b1;
            t_val  = TW'(NDF - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWRUP;
            ack       <= 1'b0;
            rdata     <= '0;
            rom_addr  <= '0;
            rom_word  <= 1'b1;
            rom_ce_n  <= 1'b1;
            oe_act    <= 1'b0;
            rom_a1_o  <= 1'b0;
            rom_a1_oe <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (state)
                ST_PWRUP: begin
                    if (t_done) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (req) begin
                        rom_addr  <= new_row;
                        rom_word  <= new_word;
                        rom_a1_o  <= byte_mode & addr[0];
                        rom_a1_oe <= byte_mode;
                        rom_ce_n  <= 1'b0;
                        oe_act    <= 1'b1;
                        state     <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (t_done) begin
                        rdata    <= lane_data;
                        ack      <= 1'b1;
                        rom_ce_n <= 1'b1;
                        oe_act   <= 1'b0;
                        state    <= ST_RELEASE;
                    end
                end
                default: begin
                    if (t_done) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mrom_rd_ctrl_chk.sv
module mrom_rd_ctrl_chk #(
    parameter int CLK_NS   = 10,
    parameter int PWRUP_NS = 200,
    parameter int TACC_NS  = 100,
    parameter int TOE_NS   = 25,
    parameter int TDF_NS   = 25,
    parameter int TMODE_NS = 100,
    parameter int OE_POL   = 0,
    parameter int ROW_W    = 22,
    parameter int BYTE_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic [BYTE_W-1:0] rdata_hi,
    input logic [ROW_W-1:0] rom_addr,
    input logic             rom_word,
    input logic             rom_ce_n,
    input logic             rom_oe,
    input logic             rom_a1_o,
    input logic             rom_a1_oe
);
    import mrom_pkg::*;

    localparam int NPW  = ns_to_cyc(PWRUP_NS, CLK_NS);
    localparam int NACC = max2(ns_to_cyc(TACC_NS, CLK_NS), ns_to_cyc(TOE_NS, CLK_NS));
    localparam int NCHG = max2(NACC, ns_to_cyc(TMODE_NS, CLK_NS));
    localparam int NDF  = ns_to_cyc(TDF_NS, CLK_NS);
    localparam int SAT  = 1 << 20;

    int   since_rst, low_cnt, high_cnt;
    logic last_word, chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            low_cnt   <= 0;
            high_cnt  <= 0;
            last_word <= 1'b1;
            chg       <= 1'b0;
        end else begin
            if (since_rst < SAT) since_rst <= since_rst + 1;
            low_cnt  <= rom_ce_n ? 0 : ((low_cnt < SAT) ? low_cnt + 1 : low_cnt);
            high_cnt <= rom_ce_n ? ((high_cnt < SAT) ? high_cnt + 1 : high_cnt) : 0;
            if ($fell(rom_ce_n)) begin
                chg       <= (rom_word != last_word);
                last_word <= rom_word;
            end
        end
    end

    a_r2_pwrup_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_ce_n) |-> since_rst >= NPW);

    a_r5_access_len: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_ce_n) |-> low_cnt >= NACC);

    a_r6_mode_recover: assert property (@(posedge clk) disable iff (rst)
        ($rose(rom_ce_n) && chg) |-> low_cnt >= NCHG);

    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r7_ack_after_release: assert property (@(posedge clk) disable iff (rst)
        ack |-> rom_ce_n);

    a_r8_release_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_ce_n) |-> high_cnt >= NDF);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n)) |->
            ($stable(rom_addr) && $stable(rom_word) && $stable(rom_a1_o)));

    a_r4_pin_driven: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && !rom_word) |-> rom_a1_oe);

    a_r3_pin_released: assert property (@(posedge clk) disable iff (rst)
        rom_word |-> !rom_a1_oe);

    a_r4_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (ack && !rom_word) |-> rdata_hi == '0);

    a_r10_oe_level: assert property (@(posedge clk) disable iff (rst)
        rom_oe == ((OE_POL == 0) ? rom_ce_n : (OE_POL == 1) ? !rom_ce_n : 1'b0));

endmodule

bind mrom_rd_ctrl mrom_rd_ctrl_chk #(
    .CLK_NS   (CLK_NS),
    .PWRUP_NS (PWRUP_NS),
    .TACC_NS  (TACC_NS),
    .TOE_NS   (TOE_NS),
    .TDF_NS   (TDF_NS),
    .TMODE_NS (TMODE_NS),
    .OE_POL   (OE_POL),
    .ROW_W    (ROW_W),
    .BYTE_W   (DATA_W / 2)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .rdata_hi  (rdata[DATA_W-1:DATA_W/2]),
    .rom_addr  (rom_addr),
    .rom_word  (rom_word),
    .rom_ce_n  (rom_ce_n),
    .rom_oe    (rom_oe),
    .rom_a1_o  (rom_a1_o),
    .rom_a1_oe (rom_a1_oe)
);

// File: tb/mrom_rd_ctrl_test.sv
module mrom_rd_ctrl_test;
    localparam int NPW  = 20;   // 200 ns at 10 ns
    localparam int NACC = 10;   // max(100, 25) ns
    localparam int NDF  = 3;    // 25 ns

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [22:0] addr = '0;
    logic        byte_mode = 1'b0;
    logic        ack;
    logic [15:0] rdata;
    logic [21:0] rom_addr;
    logic        rom_word, rom_ce_n, rom_oe, rom_a1_o, rom_a1_oe;
    logic [15:0] rom_dq_i;

    logic        ack_h, ack_d;
    logic [15:0] rd_h, rd_d;
    logic [21:0] ra_h, ra_d;
    logic        w_h, w_d, ce_h, ce_d, oe_h, oe_d, a1_h, a1_d, a1e_h, a1e_d;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    mrom_rd_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .byte_mode(byte_mode),
        .ack(ack), .rdata(rdata), .rom_addr(rom_addr), .rom_word(rom_word),
        .rom_ce_n(rom_ce_n), .rom_oe(rom_oe), .rom_a1_o(rom_a1_o),
        .rom_a1_oe(rom_a1_oe), .rom_dq_i(rom_dq_i)
    );

    mrom_rd_ctrl #(.OE_POL(1)) uut_hi (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .byte_mode(byte_mode),
        .ack(ack_h), .rdata(rd_h), .rom_addr(ra_h), .rom_word(w_h),
        .rom_ce_n(ce_h), .rom_oe(oe_h), .rom_a1_o(a1_h),
        .rom_a1_oe(a1e_h), .rom_dq_i(16'h0000)
    );

    mrom_rd_ctrl #(.OE_POL(2)) uut_dc (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .byte_mode(byte_mode),
        .ack(ack_d), .rdata(rd_d), .rom_addr(ra_d), .rom_word(w_d),
        .rom_ce_n(ce_d), .rom_oe(oe_d), .rom_a1_o(a1_d),
        .rom_a1_oe(a1e_d), .rom_dq_i(16'h0000)
    );

    // ROM content
    function automatic logic [15:0] wfun(input logic [21:0] row);
        return row[15:0] ^ {row[21:16], 10'b0} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] expect_data(input logic [22:0] a, input logic bm);
        logic [15:0] w;
        if (!bm) return wfun(a[21:0]);
        w = wfun(a[22:1]);
        return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    // ROM timing model: cycles of enable and of a stable mode
    int   ce_cnt = 0, mode_cnt = 0;
    logic prev_word = 1'b1;
    always @(posedge clk) begin
        ce_cnt    <= rom_ce_n ? 0 : ce_cnt + 1;
        prev_word <= rom_word;
        mode_cnt  <= (rom_word != prev_word) ? 1 : mode_cnt + 1;
    end

    always_comb begin
        logic [15:0] w;
        w = wfun(rom_addr);
        if (!rom_ce_n && !rom_oe && ce_cnt >= NACC - 1 && mode_cnt >= NACC - 1) begin
            if (rom_word && !rom_a1_oe)
                rom_dq_i = w;
            else if (!rom_word && rom_a1_oe)
                rom_dq_i = {rom_a1_o, 7'h55, rom_a1_o ? w[15:8] : w[7:0]};
            else
                rom_dq_i = 16'hDEAD;
        end else begin
            rom_dq_i = rom_word ? 16'hDEAD : {rom_a1_o, 15'h2EAD};
        end
    end

    // Width of the last chip-enable high run between accesses
    int hi_run = 0, last_gap = 0;
    always @(negedge clk) begin
        if (rom_ce_n) hi_run <= hi_run + 1;
        else if (hi_run > 0) begin
            last_gap <= hi_run;
            hi_run   <= 0;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_read(input logic [22:0] a, input logic bm, input bit wiggle,
                           output logic [15:0] d, output int low);
        logic [21:0] ra0;
        bit seen = 0;
        int cyc = 0;
        @(negedge clk);
        req = 1'b1; addr = a; byte_mode = bm; low = 0;
        while (!ack && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (!rom_ce_n) begin
                if (!seen) begin
                    ra0 = rom_addr; seen = 1;
                    chk(rom_word == !bm, "R3/R4 mode pin", rom_word, !bm);
                    chk(rom_a1_oe == bm, "R3/R4 shared pin dir", rom_a1_oe, bm);
                    chk(rom_addr == (bm ? a[22:1] : a[21:0]), "R3/R4 rom_addr",
                        rom_addr, bm ? a[22:1] : a[21:0]);
                    if (bm) chk(rom_a1_o == a[0], "R4 low bit pin", rom_a1_o, a[0]);
                    if (wiggle) begin addr = ~a; byte_mode = ~bm; end
                end else begin
                    chk(rom_addr == ra0, "R9 address held", rom_addr, ra0);
                end
                low++;
            end
        end
        d = rdata;
        chk(ack == 1'b1, "R7 ack seen", ack, 1);
        req = 1'b0; addr = a; byte_mode = bm;
        @(negedge clk);
        chk(ack == 1'b0, "R7 ack one cycle", ack, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rom_ce_n == 1, "R1 ce inactive", rom_ce_n, 1);
        chk(ack == 0, "R1 ack low", ack, 0);
        chk(rom_word == 1, "R1 word mode", rom_word, 1);
        chk(rom_a1_oe == 0, "R1 pin released", rom_a1_oe, 0);
        chk(rom_oe == 1, "R1 oe inactive", rom_oe, 1);
    endtask

    task automatic t_powerup();
        int hold = 0;
        logic [15:0] d;
        int low;
        rst = 1'b0; req = 1'b1; addr = 23'h012345; byte_mode = 1'b0;
        while (rom_ce_n && hold < 200) begin @(negedge clk); if (rom_ce_n) hold++; end
        chk(hold >= NPW, "R2 power-up hold", hold, NPW);
        req = 1'b0;
        while (!ack) @(negedge clk);
        chk(rdata == expect_data(23'h012345, 0), "R2 first read", rdata, expect_data(23'h012345, 0));
        @(negedge clk);
        do_read(23'h3ABCDE, 0, 0, d, low);
    endtask

    task automatic t_word();
        logic [15:0] d;
        int low;
        logic [22:0] list [4] = '{23'h000000, 23'h3FFFFF, 23'h2A5A5A, 23'h1C0F3E};
        foreach (list[i]) begin
            do_read(list[i], 0, 0, d, low);
            chk(d == expect_data(list[i], 0), "R3 word data", d, expect_data(list[i], 0));
            chk(low >= NACC, "R5 enable time", low, NACC);
        end
    endtask

    task automatic t_byte();
        logic [15:0] d;
        int low;
        logic [22:0] list [4] = '{23'h000000, 23'h000001, 23'h7FFFFF, 23'h55AA33};
        foreach (list[i]) begin
            do_read(list[i], 1, 0, d, low);
            chk(d == expect_data(list[i], 1), "R4 byte data", d, expect_data(list[i], 1));
            chk(d[15:8] == 8'h00, "R4 zero extend", d[15:8], 0);
        end
    endtask

    task automatic t_mode_switch();
        logic [15:0] d;
        int low;
        do_read(23'h0F00F1, 0, 0, d, low);
        do_read(23'h0F00F1, 1, 0, d, low);
        chk(d == expect_data(23'h0F00F1, 1), "R6 data after switch", d, expect_data(23'h0F00F1, 1));
        chk(low >= NACC, "R6 recovery time", low, NACC);
        do_read(23'h123457, 0, 0, d, low);
        chk(d == expect_data(23'h123457, 0), "R6 data back to word", d, expect_data(23'h123457, 0));
    endtask

    task automatic t_stable();
        logic [15:0] d;
        int low;
        do_read(23'h246801, 1, 1, d, low);
        chk(d == expect_data(23'h246801, 1), "R9 mid-access change ignored", d, expect_data(23'h246801, 1));
    endtask

    task automatic t_busy();
        int acks = 0, falls = 0, cyc = 0;
        logic pce = 1'b1;
        @(negedge clk);
        req = 1'b1; addr = 23'h10A0B0; byte_mode = 1'b0;
        while (acks < 3 && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (pce && !rom_ce_n) falls++;
            pce = rom_ce_n;
            if (ack) begin
                acks++;
                chk(rdata == expect_data(23'h10A0B0, 0), "R7 held-request data", rdata, expect_data(23'h10A0B0, 0));
            end
        end
        req = 1'b0;
        chk(acks == 3, "R7 three acks", acks, 3);
        chk(falls == 3, "R7 one access per ack", falls, 3);
        chk(last_gap >= NDF, "R8 release gap", last_gap, NDF);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_oe();
        int cyc = 0;
        @(negedge clk);
        chk(rom_oe == 1 && oe_h == 0 && oe_d == 0, "R10 idle oe levels", {rom_oe, oe_h, oe_d}, 3'b100);
        req = 1'b1; addr = 23'h000777; byte_mode = 1'b0;
        while (rom_ce_n && cyc < 100) begin @(negedge clk); cyc++; end
        chk(rom_oe == 0, "R10 active-low oe", rom_oe, 0);
        chk(oe_h == 1, "R10 active-high oe", oe_h, 1);
        chk(oe_d == 0, "R10 fixed oe", oe_d, 0);
        req = 1'b0;
        while (!ack) @(negedge clk);
        @(negedge clk);
        chk(oe_d == 0, "R10 fixed oe after", oe_d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_powerup();
        t_word();
        t_byte();
        t_mode_switch();
        t_stable();
        t_busy();
        t_oe();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule